// File: doc/BRIEF.md
# Flat Pointer Aperture Classifier

This unit sits in a shader memory pipeline and routes every flat pointer to one of three places: translated memory, the on-chip shared memory, or the per-thread private scratch region. It looks at the pointer, the access length, two mode-select bits and a set of per-process window registers. Translated requests leave with a 48-bit address, a translation-select bit (ATC: 1 means the host page tables, 0 means the device page tables) and a memory-type tag. The outputs are registered, so results appear one clock after the inputs.

Three pointer modes are supported: a 64-bit host-space mode, a 32-bit host-space mode and a 64-bit device-space mode. Each window is inclusive and 64 KB granular. A pointer inside the device window is rebased against that window's start. A pointer in the non-canonical gap of the 64-bit space that hits no window is a violation, and so is any access whose first and last bytes land in different regions.

Top module: `flat_ap_router`

## Requirements
- R1: Mode decode: mode_atc=1 with mode_p32=0 selects 64-bit host mode, mode_atc=1 with mode_p32=1 selects 32-bit host mode, and mode_atc=0 selects 64-bit device mode whatever mode_p32 holds. In device mode xl_atc is always 0.
- R2: A window covers the addresses from {base,16'h0000} to {limit,16'hFFFF}, both ends included. base and limit are each 48 bits and form address bits [63:16].
- R3: A pointer in the device window gives cls=2'b00, xl_atc=0, xl_addr=(pointer - {gvm_base,16'h0})[47:0] and mt=gvm_mt.
- R4: A pointer that hits no window gives cls=2'b00, mt=dflt_mt and xl_addr=pointer[47:0]. xl_atc is 1 in both host modes and 0 in device mode.
- R5: In the 64-bit modes, a pointer whose bits [63:47] are neither all zeros nor all ones and that hits no window is a violation.
- R6: If the byte at pointer+len_m1 (len_m1 is the access length minus one) lies in a different region than the byte at the pointer, the access is a violation. Addresses wrap at 32 bits in 32-bit mode and at 64 bits otherwise.
- R7: The spare window exists only in 64-bit host mode. A hit there gives cls=2'b00, xl_atc=1, xl_addr=pointer[47:0] and mt=spr_mt. In the other modes the spare registers have no effect.
- R8: In 32-bit mode only pointer bits [31:0] count. The shared window and the private window are each the 64 KB at {base[15:0],16'h0000}, and a zero base[15:0] turns that window off. The device window is compared against the zero-extended pointer, and there is no gap check.
- R9: A shared hit gives cls=2'b01 and a private hit gives cls=2'b10. Both give xl_addr=0, xl_atc=0 and mt=0.
- R10: When windows overlap, the priority is shared, then private, then device, then spare, then default.
- R11: A violation gives cls=2'b11, viol=1, xl_addr=0, xl_atc=0 and mt=0. viol is 0 for every other class.
- R12: All outputs are zero while rst_n is low. After reset, the outputs show the result for the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr | input | 64 | Flat pointer |
| len_m1 | input | LEN_W | Access length in bytes minus one |
| mode_atc | input | 1 | Dispatch host-space select |
| mode_p32 | input | 1 | 32-bit pointer select |
| shr_base | input | 48 | Shared window base [63:16] |
| shr_lim | input | 48 | Shared window limit [63:16] |
| prv_base | input | 48 | Private window base [63:16] |
| prv_lim | input | 48 | Private window limit [63:16] |
| gvm_base | input | 48 | Device window base [63:16] |
| gvm_lim | input | 48 | Device window limit [63:16] |
| spr_base | input | 48 | Spare window base [63:16] |
| spr_lim | input | 48 | Spare window limit [63:16] |
| gvm_mt | input | MT_W | Memory type for device window hits |
| spr_mt | input | MT_W | Memory type for spare window hits |
| dflt_mt | input | MT_W | Memory type for default-space accesses |
| cls | output | 2 | Target class: 00 translated, 01 shared, 10 private, 11 violation |
| xl_addr | output | 48 | Translated address |
| xl_atc | output | 1 | Translation select |
| mt | output | MT_W | Memory type |
| viol | output | 1 | Memory violation |

## Verification
Random pointers are placed on and around every window edge, in the gap and in both canonical halves. The mode bits and two window layouts are also randomised, so each run covers every mode and layout combination, including accesses that cross a window edge. The directed cases then pick out the behaviours that random stimulus tends to miss:
- the exact first and last byte of a window, which tests the inclusive bounds;
- the byte just past a limit, which separates a window hit from the default space;
- a spare-window pointer in each mode, which shows the mode gating;
- a zero 32-bit base, which tests the window switch-off;
- overlapping windows, which test the priority order;
- mode_p32 toggled in device mode, which shows that the bit is ignored there.

// File: rtl/flat_ap_router.sv
module flat_ap_router #(
  parameter int LEN_W = 4,
  parameter int MT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      ptr,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             mode_atc,
  input  logic             mode_p32,
  input  logic [47:0]      shr_base,
  input  logic [47:0]      shr_lim,
  input  logic [47:0]      prv_base,
  input  logic [47:0]      prv_lim,
  input  logic [47:0]      gvm_base,
  input  logic [47:0]      gvm_lim,
  input  logic [47:0]      spr_base,
  input  logic [47:0]      spr_lim,
  input  logic [MT_W-1:0]  gvm_mt,
  input  logic [MT_W-1:0]  spr_mt,
  input  logic [MT_W-1:0]  dflt_mt,
  output logic [1:0]       cls,
  output logic [47:0]      xl_addr,
  output logic             xl_atc,
  output logic [MT_W-1:0]  mt,
  output logic             viol
);

  typedef enum logic [2:0] {RG_DFLT, RG_SHR, RG_PRV, RG_GVM, RG_SPR, RG_HOLE} rg_t;

  logic hsa64, hsa32;
  assign hsa64 = mode_atc & ~mode_p32;
  assign hsa32 = mode_atc & mode_p32;

  function automatic logic inside_win(input logic [63:0] a, input logic [47:0] b, input logic [47:0] l);
    return (a >= {b, 16'h0000}) && (a <= {l, 16'hFFFF});
  endfunction

  function automatic logic hit32(input logic [63:0] a, input logic [47:0] b);
    return (b[15:0] != 16'h0) && (a[31:16] == b[15:0]);
  endfunction

  function automatic rg_t region(input logic [63:0] a);
    logic shr_h, prv_h, gap;
    shr_h = hsa32 ? hit32(a, shr_base) : inside_win(a, shr_base, shr_lim);
    prv_h = hsa32 ? hit32(a, prv_base) : inside_win(a, prv_base, prv_lim);
    gap   = !hsa32 && !((a[63:47] == 17'h0) || (a[63:47] == 17'h1FFFF));
    if (shr_h)                                     return RG_SHR;
    else if (prv_h)                                return RG_PRV;
    else if (inside_win(a, gvm_base, gvm_lim))     return RG_GVM;
    else if (hsa64 && inside_win(a, spr_base, spr_lim)) return RG_SPR;
    else if (gap)                                  return RG_HOLE;
    else                                           return RG_DFLT;
  endfunction

  logic [63:0] a_first, a_last;
  logic [31:0] last32;
  rg_t         rg_first, rg_last;
  logic        bad;

  assign last32  = ptr[31:0] + {{(32-LEN_W){1'b0}}, len_m1};
  assign a_first = hsa32 ? {32'h0, ptr[31:0]} : ptr;
  assign a_last  = hsa32 ? {32'h0, last32} : ptr + {{(64-LEN_W){1'b0}}, len_m1};
  assign rg_first = region(a_first);
  assign rg_last  = region(a_last);
  assign bad      = (rg_first == RG_HOLE) || (rg_first != rg_last);

  logic [1:0]      cls_d;
  logic [47:0]     addr_d;
  logic            atc_d;
  logic [MT_W-1:0] mt_d;

  always_comb begin
    cls_d  = 2'b00;
    addr_d = '0;
    atc_d  = 1'b0;
    mt_d   = '0;
    if (bad) begin
      cls_d = 2'b11;
    end else begin
      case (rg_first)
        RG_SHR: cls_d = 2'b01;
        RG_PRV: cls_d = 2'b10;
        RG_GVM: begin
          addr_d = a_first[47:0] - {gvm_base[31:0], 16'h0000};
          mt_d   = gvm_mt;
        end
        RG_SPR: begin
          addr_d = a_first[47:0];
          atc_d  = 1'b1;
          mt_d   = spr_mt;
        end
        default: begin
          addr_d = a_first[47:0];
          atc_d  = mode_atc;
          mt_d   = dflt_mt;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls     <= 2'b00;
      xl_addr <= '0;
      xl_atc  <= 1'b0;
      mt      <= '0;
      viol    <= 1'b0;
    end else begin
      cls     <= cls_d;
      xl_addr <= addr_d;
      xl_atc  <= atc_d;
      mt      <= mt_d;
      viol    <= bad;
    end
  end

endmodule

module flat_ap_router_chk #(
  parameter int MT_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_atc,
  input logic            mode_p32,
  input logic [1:0]      cls,
  input logic [47:0]     xl_addr,
  input logic            xl_atc,
  input logic [MT_W-1:0] mt,
  input logic            viol
);

  AST_VIOL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (cls == 2'b11 && xl_addr == 48'h0 && !xl_atc && mt == '0)); // R11

  AST_LOCAL_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == 2'b01 || cls == 2'b10) |-> (xl_addr == 48'h0 && !xl_atc && !viol)); // R9

  AST_DEVICE_MODE_NO_ATC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mode_atc) |-> !xl_atc); // R1

  AST_PTR32_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_atc && mode_p32) && cls == 2'b00 && xl_atc) |-> (xl_addr[47:32] == 16'h0)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (cls == 2'b00 && !viol && xl_addr == 48'h0)); // R12

endmodule

bind flat_ap_router flat_ap_router_chk #(.MT_W(MT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_atc(mode_atc), .mode_p32(mode_p32),
  .cls(cls), .xl_addr(xl_addr), .xl_atc(xl_atc), .mt(mt), .viol(viol)
);

// File: tb/test_flat_ap_router.sv
`timescale 1ns/1ps
module test_flat_ap_router;
  localparam int LEN_W = 4;
  localparam int MT_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] ptr = '0;
  logic [LEN_W-1:0] len_m1 = '0;
  logic mode_atc = 1'b0, mode_p32 = 1'b0;
  logic [47:0] shr_base = '0, shr_lim = '0, prv_base = '0, prv_lim = '0;
  logic [47:0] gvm_base = '0, gvm_lim = '0, spr_base = '0, spr_lim = '0;
  logic [MT_W-1:0] gvm_mt = 2'd1, spr_mt = 2'd2, dflt_mt = 2'd3;
  logic [1:0] cls;
  logic [47:0] xl_addr;
  logic xl_atc;
  logic [MT_W-1:0] mt;
  logic viol;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flat_ap_router #(.LEN_W(LEN_W), .MT_W(MT_W)) i_flat_ap_router (.*);

  // region codes: 0 default, 1 shared, 2 private, 3 device, 4 spare, 7 gap
  function automatic int where(input logic [63:0] a);
    bit h32 = mode_atc && mode_p32;
    bit h64 = mode_atc && !mode_p32;
    logic [63:0] lo [4], hi [4];
    bit on [4];
    lo[0] = {shr_base,16'h0}; hi[0] = {shr_lim,16'hFFFF}; on[0] = 1;
    lo[1] = {prv_base,16'h0}; hi[1] = {prv_lim,16'hFFFF}; on[1] = 1;
    lo[2] = {gvm_base,16'h0}; hi[2] = {gvm_lim,16'hFFFF}; on[2] = 1;
    lo[3] = {spr_base,16'h0}; hi[3] = {spr_lim,16'hFFFF}; on[3] = h64;
    if (h32) begin
      lo[0] = {32'h0, shr_base[15:0], 16'h0}; hi[0] = lo[0] + 64'hFFFF; on[0] = (shr_base[15:0] != 0);
      lo[1] = {32'h0, prv_base[15:0], 16'h0}; hi[1] = lo[1] + 64'hFFFF; on[1] = (prv_base[15:0] != 0);
    end
    for (int k = 0; k < 4; k++)
      if (on[k] && a >= lo[k] && a <= hi[k]) return k + 1;
    if (!h32 && a[63:47] != 17'h0 && a[63:47] != 17'h1FFFF) return 7;
    return 0;
  endfunction

  task automatic check(input string req);
    logic [63:0] f, l;
    int r0, r1;
    logic [1:0] ec; logic [47:0] ea; logic ex; logic [1:0] em; logic ev;
    if (mode_atc && mode_p32) begin
      f = {32'h0, ptr[31:0]};
      l = {32'h0, ptr[31:0] + 32'(len_m1)};
    end else begin
      f = ptr; l = ptr + 64'(len_m1);
    end
    r0 = where(f); r1 = where(l);
    ec = 0; ea = 0; ex = 0; em = 0; ev = 0;
    if (r0 == 7 || r0 != r1) begin ec = 2'b11; ev = 1; end
    else if (r0 == 1) ec = 2'b01;
    else if (r0 == 2) ec = 2'b10;
    else if (r0 == 3) begin ea = 48'(f - {gvm_base,16'h0}); em = gvm_mt; end
    else if (r0 == 4) begin ea = f[47:0]; ex = 1; em = spr_mt; end
    else begin ea = f[47:0]; ex = mode_atc; em = dflt_mt; end
    @(posedge clk); @(negedge clk);
    n_chk++;
    if ({cls, xl_addr, xl_atc, mt, viol} !== {ec, ea, ex, em, ev}) begin
      n_bad++;
      $display("FAIL %s ptr=%h got cls=%b addr=%h atc=%b mt=%0d viol=%b exp cls=%b addr=%h atc=%b mt=%0d viol=%b",
               req, ptr, cls, xl_addr, xl_atc, mt, viol, ec, ea, ex, em, ev);
    end
  endtask

  task automatic cfg_a();
    shr_base = 48'h0001_0000_0000; shr_lim = 48'h0001_0000_FFFF;
    prv_base = 48'h0002_0000_0000; prv_lim = 48'h0002_0000_FFFF;
    gvm_base = 48'h2000_0000_0000; gvm_lim = 48'h2000_00FF_FFFF;
    spr_base = 48'h0000_7000_0000; spr_lim = 48'h0000_7000_0FFF;
  endtask

  task automatic cfg_b();
    shr_base = 48'h0000_0000_1234; shr_lim = 48'h0000_0000_1234;
    prv_base = 48'h0000_0000_5678; prv_lim = 48'h0000_0000_5678;
    gvm_base = 48'h0000_0000_8000; gvm_lim = 48'h0000_0000_BFFF;
    spr_base = 48'h0000_0000_C000; spr_lim = 48'h0000_0000_CFFF;
  endtask

  task automatic go(input logic [63:0] p, input int ln, input bit atc, input bit p32, input string req);
    ptr = p; len_m1 = LEN_W'(ln); mode_atc = atc; mode_p32 = p32;
    check(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    cfg_a();
    @(negedge clk); @(negedge clk);
    n_chk++;
    if ({cls, xl_addr, xl_atc, mt, viol} !== '0) begin
      n_bad++; $display("FAIL R12 reset outputs got %h exp 0", {cls, xl_addr, xl_atc, mt, viol});
    end
    rst_n = 1'b1;
    // directed
    go(64'h2000_0000_0000_0000, 0, 1, 0, "R3 device base");
    go(64'h2000_00FF_FFFF_FFFF, 0, 1, 0, "R2 device limit inclusive");
    go(64'h2000_0100_0000_0000, 0, 1, 0, "R5 past device limit in gap");
    go(64'h0000_1234_5678_9ABC, 3, 1, 0, "R4 host default");
    go(64'h0000_1234_5678_9ABC, 3, 0, 1, "R1 device mode ignores p32");
    go(64'h0000_1234_5678_9ABC, 3, 0, 0, "R4 device mode default");
    go(64'hFFFF_8000_0000_0010, 0, 1, 0, "R4 upper canonical");
    go(64'h0001_0000_0000_0100, 7, 1, 0, "R9 shared hit");
    go(64'h0002_0000_FFFF_FFF8, 7, 1, 0, "R9 private hit at top");
    go(64'h4000_0000_0000_0000, 0, 1, 0, "R5 gap violation");
    go(64'h2000_00FF_FFFF_FFFC, 7, 1, 0, "R6 straddle device to gap");
    go(64'h0000_7000_0FFF_FFFC, 7, 1, 0, "R6 straddle spare to default");
    go(64'h0000_7000_0000_0040, 0, 1, 0, "R7 spare in host 64");
    go(64'h0000_7000_0000_0040, 0, 0, 0, "R7 spare ignored in device mode");
    go(64'h0001_0000_0000_0000, 0, 1, 1, "R8 zero 32-bit base disables");
    cfg_b();
    go(64'hDEAD_BEEF_1234_0010, 3, 1, 1, "R8 32-bit shared hit");
    go(64'h0000_0000_5678_FFFF, 0, 1, 1, "R8 32-bit private last byte");
    go(64'h0000_0000_5679_0000, 0, 1, 1, "R8 32-bit private end");
    go(64'h0000_0000_1234_FFFE, 3, 1, 1, "R6 32-bit straddle");
    go(64'hFFFF_FFFF_FFFF_FFFE, 3, 1, 1, "R6 32-bit wrap");
    go(64'h0000_0000_9000_0000, 0, 1, 1, "R3 32-bit device rebase");
    cfg_a(); spr_base = 48'h0001_0000_0000; gvm_base = 48'h0001_0000_0000;
    go(64'h0001_0000_0000_0008, 0, 1, 0, "R10 shared beats device and spare");
    shr_base = 48'h0003_0000_0000; shr_lim = 48'h0003_0000_0000;
    go(64'h0001_0000_0000_0008, 0, 1, 0, "R10 device beats spare");
    // random
    for (int i = 0; i < 1500; i++) begin
      int pick;
      logic [63:0] off;
      if ($urandom % 2) cfg_a(); else cfg_b();
      mode_atc = 1'($urandom); mode_p32 = 1'($urandom);
      len_m1 = LEN_W'($urandom);
      off = 64'($signed(8'($urandom)));
      pick = $urandom % 7;
      case (pick)
        0: ptr = {shr_base, 16'h0} + off;
        1: ptr = {prv_lim, 16'hFFFF} + off;
        2: ptr = {gvm_lim, 16'hFFFF} + off;
        3: ptr = {spr_base, 16'h0} + off;
        4: ptr = {$urandom, $urandom};
        5: ptr = {32'hFFFF_FFFF, $urandom};
        default: ptr = {gvm_base, 16'h0} + off;
      endcase
      check("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule